// File: doc/BRIEF.md
# Cartridge Bank Mapper

This block sits between an 8-bit console CPU and the video unit on one side and the program and pattern ROMs of a cartridge on the other. The CPU programs it by writing into the upper half of its address space. One register picks which bank slot the next data write fills, and also carries two mode bits. A data register loads that slot. A third register picks how the nametables are mirrored.

The CPU program space above 0x8000 is split into four 8 KB windows. Two of them hold banks the CPU chooses and two hold the last two banks of the ROM. A swap mode moves the first chosen bank from the lowest window to the third window. The video pattern space is split into eight 1 KB windows. Two slots fill a 2 KB window pair each, and four slots fill one 1 KB window each. An invert mode exchanges the lower and upper 4 KB halves.

Address translation is combinational from the registered state, so a new mapping holds for the first access after the write edge. The ROM sizes are parameters, and bank numbers wrap to the banks that exist.

Top module: `bank_mapper`

## Requirements
- R1: A write is taken only when `cpu_we_i` is high and `cpu_addr_i[15]` is 1. It is decoded on address bits 15, 14, 13 and 0 alone: {14:13,0} = 000 is select, 001 is data and 010 is mirroring (so 0xB002 aliases 0xA000). Every other write (0xA001, 0xC000–0xFFFF, bit 15 clear) changes no mapping and no mirroring.
- R2: After reset the select register is 0, program banks are 0 and 1, the six pattern slots hold pages 0, 2, 4, 5, 6 and 7, and mirroring is 0.
- R3: Select value bits [2:0] = 0 or 1 make a data write load pattern pair slot 0 or 1 with page (data<<1) with bit 0 cleared. The pair maps pattern window 2k to that page and window 2k+1 to page+1.
- R4: Select value bits [2:0] = 2..5 make a data write load 1 KB slot 0..3 with page (data<<1), unmasked. That slot maps windows 4..7.
- R5: Select value bits [2:0] = 6 or 7 make a data write load program bank register 0 or 1 with the data value.
- R6: With select bit 6 clear, program windows 0..3 (`cpu_addr_i[14:13]`) map to (prg0, prg1, last-1, last). With bit 6 set they map to (last-1, prg1, prg0, last). The output is {bank, `cpu_addr_i[12:0]`}.
- R7: With select bit 7 set, pattern window w is translated as window w XOR 4. The output is {page, `ppu_addr_i[9:0]`}.
- R8: `mirror_o` equals bits [1:0] of the last write to the mirroring register: 0 vertical, 1 horizontal, 2 single-screen low, 3 single-screen high.
- R9: Program bank numbers are truncated to PRG_BANK_W bits and pattern pages to CHR_BANK_W bits, so oversized values wrap.
- R10: A register write takes effect at the clock edge that samples it. The translated outputs change after that edge and not before it.
- R11: With CHR_PRESENT = 0, the pattern address passes through unchanged (zero-extended) whatever the select mode and writes.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_addr_i | input | 16 | CPU address, used for writes and program translation |
| cpu_data_i | input | 8 | CPU write data |
| cpu_we_i | input | 1 | CPU write strobe |
| ppu_addr_i | input | 13 | Video pattern address |
| prg_addr_o | output | PRG_BANK_W+13 | Banked program ROM address |
| chr_addr_o | output | CHR_BANK_W+10 | Banked pattern ROM address |
| mirror_o | output | 2 | Nametable mirroring code |

## Verification
The embedded assertions check on every cycle these properties:
- writes outside the decoded slots leave the whole register state unchanged;
- a mirroring or program-bank write lands in the next cycle;
- pair pages stay even;
- the top program window always holds the last bank;
- a pattern-less build keeps its slots at zero.

The window maps under both swap and invert modes, the page+1 pairing, the wrap of oversized bank numbers, address aliasing, the exact edge at which a mapping changes, and the reset values all depend on sequences of writes. Only the bench's scenarios show them.

// File: rtl/mapper_pkg.sv
package mapper_pkg;

  typedef enum logic [1:0] {
    MIR_VERT   = 2'd0,
    MIR_HORZ   = 2'd1,
    MIR_ONE_LO = 2'd2,
    MIR_ONE_HI = 2'd3
  } mirror_e;

  typedef enum logic [1:0] {
    REG_NONE,
    REG_SELECT,
    REG_DATA,
    REG_MIRROR
  } reg_kind_e;

  localparam int unsigned NUM_CHR_SLOTS = 6;
  localparam int unsigned NUM_PRG_SLOTS = 2;
  localparam int unsigned PRG_PAGE_BITS = 13;
  localparam int unsigned CHR_PAGE_BITS = 10;

  // decode on bits 15, 14, 13, 0 only
  function automatic reg_kind_e decode_reg(input logic [15:0] a);
    reg_kind_e k;
    k = REG_NONE;
    if (a[15]) begin
      unique case ({a[14:13], a[0]})
        3'b000:  k = REG_SELECT;
        3'b001:  k = REG_DATA;
        3'b010:  k = REG_MIRROR;
        default: k = REG_NONE;
      endcase
    end
    return k;
  endfunction

endpackage

// File: rtl/mapper_regs.sv
module mapper_regs
  import mapper_pkg::*;
#(
  parameter int unsigned PRG_BANK_W  = 4,
  parameter int unsigned CHR_BANK_W  = 7,
  parameter bit          CHR_PRESENT = 1'b1
) (
  input  logic                                    clk_i,
  input  logic                                    rst_ni,
  input  logic [15:0]                             cpu_addr_i,
  input  logic [7:0]                              cpu_data_i,
  input  logic                                    cpu_we_i,
  output logic                                    swap_o,
  output logic                                    invert_o,
  output logic [NUM_PRG_SLOTS-1:0][PRG_BANK_W-1:0] prg_o,
  output logic [NUM_CHR_SLOTS-1:0][CHR_BANK_W-1:0] chr_o,
  output mirror_e                                 mirror_o
);

  reg_kind_e                                kind;
  logic [2:0]                               target_q;
  logic                                     swap_q, invert_q;
  logic [NUM_PRG_SLOTS-1:0][PRG_BANK_W-1:0] prg_q;
  logic [NUM_CHR_SLOTS-1:0][CHR_BANK_W-1:0] chr_q;
  mirror_e                                  mirror_q;
  logic [CHR_BANK_W-1:0]                    page_raw;
  logic                                     data_wr;
  logic                                     unused_sel_bits;

  assign kind            = decode_reg(cpu_addr_i);
  assign data_wr         = cpu_we_i && (kind == REG_DATA);
  assign page_raw        = CHR_BANK_W'({cpu_data_i, 1'b0});
  assign unused_sel_bits = ^cpu_data_i[5:3];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      target_q <= '0;
      swap_q   <= 1'b0;
      invert_q <= 1'b0;
    end else if (cpu_we_i && kind == REG_SELECT) begin
      target_q <= cpu_data_i[2:0];
      swap_q   <= cpu_data_i[6];
      invert_q <= cpu_data_i[7];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                               mirror_q <= MIR_VERT;
    else if (cpu_we_i && kind == REG_MIRROR)   mirror_q <= mirror_e'(cpu_data_i[1:0]);
  end

  for (genvar p = 0; p < NUM_PRG_SLOTS; p++) begin : g_prg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        prg_q[p] <= PRG_BANK_W'(p);
      else if (data_wr && target_q == 3'(6 + p))
        prg_q[p] <= PRG_BANK_W'(cpu_data_i);
    end
  end

  for (genvar c = 0; c < NUM_CHR_SLOTS; c++) begin : g_chr
    localparam int unsigned RST_PAGE = (c < 2) ? 2 * c : c + 2;
    logic [CHR_BANK_W-1:0] wr_page;
    // pair slots are 2 KB aligned
    if (c < 2) begin : g_pair
      assign wr_page = page_raw & ~CHR_BANK_W'(1);
    end else begin : g_single
      assign wr_page = page_raw;
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        chr_q[c] <= CHR_PRESENT ? CHR_BANK_W'(RST_PAGE) : '0;
      else if (CHR_PRESENT && data_wr && target_q == 3'(c))
        chr_q[c] <= wr_page;
    end
  end

  assign swap_o   = swap_q;
  assign invert_o = invert_q;
  assign prg_o    = prg_q;
  assign chr_o    = chr_q;
  assign mirror_o = mirror_q;

  // R1: writes that hit no register leave all state alone
  a_r1_no_side_effect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cpu_we_i || !cpu_addr_i[15] || cpu_addr_i[14])
    |=> $stable(target_q) && $stable(swap_q) && $stable(invert_q)
        && $stable(mirror_q) && $stable(prg_q) && $stable(chr_q));

  a_r8_mirror_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_we_i && cpu_addr_i[15:13] == 3'b101 && !cpu_addr_i[0])
    |=> (mirror_q == mirror_e'($past(cpu_data_i[1:0]))));

  a_r5_prg_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_we_i && cpu_addr_i[15:13] == 3'b100 && cpu_addr_i[0] && target_q == 3'd6)
    |=> (prg_q[0] == $past(cpu_data_i[PRG_BANK_W-1:0])));

  a_r3_pair_even: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_we_i |=> (!chr_q[0][0] && !chr_q[1][0]));

  if (!CHR_PRESENT) begin : g_no_chr_chk
    a_r11_slots_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cpu_we_i |=> (chr_q == '0));
  end

endmodule

// File: rtl/prg_xlate.sv
module prg_xlate
  import mapper_pkg::*;
#(
  parameter int unsigned PRG_BANK_W = 4,
  localparam int unsigned PRG_AW    = PRG_BANK_W + PRG_PAGE_BITS
) (
  input  logic                                    swap_i,
  input  logic [NUM_PRG_SLOTS-1:0][PRG_BANK_W-1:0] prg_i,
  input  logic [14:0]                             addr_i,
  output logic [PRG_AW-1:0]                       addr_o
);

  localparam logic [PRG_BANK_W-1:0] LAST_BANK = '1;
  localparam logic [PRG_BANK_W-1:0] PREV_BANK = LAST_BANK - 1'b1;

  logic [PRG_BANK_W-1:0] bank;

  always_comb begin
    unique case (addr_i[14:13])
      2'd0:    bank = swap_i ? PREV_BANK : prg_i[0];
      2'd1:    bank = prg_i[1];
      2'd2:    bank = swap_i ? prg_i[0] : PREV_BANK;
      default: bank = LAST_BANK;
    endcase
  end

  assign addr_o = {bank, addr_i[PRG_PAGE_BITS-1:0]};

endmodule

// File: rtl/chr_xlate.sv
module chr_xlate
  import mapper_pkg::*;
#(
  parameter int unsigned CHR_BANK_W  = 7,
  parameter bit          CHR_PRESENT = 1'b1,
  localparam int unsigned CHR_AW     = CHR_BANK_W + CHR_PAGE_BITS
) (
  input  logic                                    invert_i,
  input  logic [NUM_CHR_SLOTS-1:0][CHR_BANK_W-1:0] chr_i,
  input  logic [12:0]                             addr_i,
  output logic [CHR_AW-1:0]                       addr_o
);

  if (CHR_PRESENT) begin : g_rom
    logic [2:0]            eff_win;
    logic [CHR_BANK_W-1:0] page;

    assign eff_win = addr_i[12:10] ^ {invert_i, 2'b00};

    always_comb begin
      if (eff_win[2]) page = chr_i[3'(eff_win[1:0]) + 3'd2];
      else            page = chr_i[{2'b00, eff_win[1]}] | CHR_BANK_W'(eff_win[0]);
    end

    assign addr_o = {page, addr_i[CHR_PAGE_BITS-1:0]};
  end else begin : g_ram
    logic unused_chr;
    assign unused_chr = ^{invert_i, chr_i};
    assign addr_o     = CHR_AW'(addr_i);
  end

endmodule

// File: rtl/bank_mapper.sv
module bank_mapper
  import mapper_pkg::*;
#(
  parameter int unsigned PRG_BANK_W  = 4,
  parameter int unsigned CHR_BANK_W  = 7,
  parameter bit          CHR_PRESENT = 1'b1,
  localparam int unsigned PRG_AW     = PRG_BANK_W + PRG_PAGE_BITS,
  localparam int unsigned CHR_AW     = CHR_BANK_W + CHR_PAGE_BITS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [15:0]       cpu_addr_i,
  input  logic [7:0]        cpu_data_i,
  input  logic              cpu_we_i,
  input  logic [12:0]       ppu_addr_i,
  output logic [PRG_AW-1:0] prg_addr_o,
  output logic [CHR_AW-1:0] chr_addr_o,
  output logic [1:0]        mirror_o
);

  logic                                     swap, invert;
  logic [NUM_PRG_SLOTS-1:0][PRG_BANK_W-1:0] prg_bank;
  logic [NUM_CHR_SLOTS-1:0][CHR_BANK_W-1:0] chr_page;
  mirror_e                                  mirror;

  mapper_regs #(
    .PRG_BANK_W (PRG_BANK_W),
    .CHR_BANK_W (CHR_BANK_W),
    .CHR_PRESENT(CHR_PRESENT)
  ) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cpu_addr_i(cpu_addr_i),
    .cpu_data_i(cpu_data_i),
    .cpu_we_i  (cpu_we_i),
    .swap_o    (swap),
    .invert_o  (invert),
    .prg_o     (prg_bank),
    .chr_o     (chr_page),
    .mirror_o  (mirror)
  );

  prg_xlate #(.PRG_BANK_W(PRG_BANK_W)) u_prg (
    .swap_i(swap),
    .prg_i (prg_bank),
    .addr_i(cpu_addr_i[14:0]),
    .addr_o(prg_addr_o)
  );

  chr_xlate #(
    .CHR_BANK_W (CHR_BANK_W),
    .CHR_PRESENT(CHR_PRESENT)
  ) u_chr (
    .invert_i(invert),
    .chr_i   (chr_page),
    .addr_i  (ppu_addr_i),
    .addr_o  (chr_addr_o)
  );

  assign mirror_o = mirror;

  // R6: top program window always holds the final bank
  a_r6_last_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_addr_i[14:13] == 2'b11) |-> (&prg_addr_o[PRG_AW-1:PRG_PAGE_BITS]));

endmodule

// File: tb/bank_mapper_bench.sv
module bank_mapper_bench;

  localparam int PW = 4;
  localparam int CW = 7;

  typedef struct packed {
    logic        we;
    logic [15:0] wa;
    logic [7:0]  wd;
    logic [15:0] pa;
    logic [12:0] va;
    logic [16:0] ep;
    logic [16:0] ec;
    logic [1:0]  em;
  } vec_t;

  localparam int NV = 33;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 16'h0000, 8'h00, 16'h8123, 13'h0055, 17'h00123, 17'h00055, 2'd0}, // R2 win0
    '{1'b0, 16'h0000, 8'h00, 16'hE123, 13'h0455, 17'h1E123, 17'h00455, 2'd0}, // R2
    '{1'b0, 16'h0000, 8'h00, 16'hC123, 13'h1455, 17'h1C123, 17'h01455, 2'd0}, // R2
    '{1'b0, 16'h0000, 8'h00, 16'hA123, 13'h1C55, 17'h02123, 17'h01C55, 2'd0}, // R2
    '{1'b0, 16'h0000, 8'h00, 16'hA123, 13'h0855, 17'h02123, 17'h00855, 2'd0}, // R2
    '{1'b1, 16'h8000, 8'h06, 16'h8123, 13'h0055, 17'h00123, 17'h00055, 2'd0}, // R1 select only
    '{1'b1, 16'h8001, 8'h05, 16'h8123, 13'h0055, 17'h0A123, 17'h00055, 2'd0}, // R5 prg0
    '{1'b1, 16'h8000, 8'h07, 16'hA123, 13'h0055, 17'h02123, 17'h00055, 2'd0},
    '{1'b1, 16'h8001, 8'h09, 16'hA123, 13'h0055, 17'h12123, 17'h00055, 2'd0}, // R5 prg1
    '{1'b1, 16'h8001, 8'h13, 16'hA123, 13'h0055, 17'h06123, 17'h00055, 2'd0}, // R9 wrap
    '{1'b0, 16'h8001, 8'h3F, 16'hA123, 13'h0055, 17'h06123, 17'h00055, 2'd0}, // R1 we low
    '{1'b1, 16'h8000, 8'h46, 16'h8123, 13'h0055, 17'h1C123, 17'h00055, 2'd0}, // R6 swap
    '{1'b0, 16'h0000, 8'h00, 16'hC123, 13'h0055, 17'h0A123, 17'h00055, 2'd0}, // R6
    '{1'b0, 16'h0000, 8'h00, 16'hE123, 13'h0055, 17'h1E123, 17'h00055, 2'd0}, // R6
    '{1'b0, 16'h0000, 8'h00, 16'hA123, 13'h0055, 17'h06123, 17'h00055, 2'd0}, // R6
    '{1'b1, 16'h8000, 8'h00, 16'h8123, 13'h0055, 17'h0A123, 17'h00055, 2'd0},
    '{1'b1, 16'h8001, 8'h0B, 16'h8123, 13'h0055, 17'h0A123, 17'h05855, 2'd0}, // R3 pair0
    '{1'b0, 16'h0000, 8'h00, 16'h8123, 13'h0455, 17'h0A123, 17'h05C55, 2'd0}, // R3 page+1
    '{1'b1, 16'h8000, 8'h01, 16'h8123, 13'h0855, 17'h0A123, 17'h00855, 2'd0},
    '{1'b1, 16'h8001, 8'hC4, 16'h8123, 13'h0855, 17'h0A123, 17'h02055, 2'd0}, // R9 R3
    '{1'b0, 16'h0000, 8'h00, 16'h8123, 13'h0C55, 17'h0A123, 17'h02455, 2'd0}, // R3
    '{1'b1, 16'h8000, 8'h03, 16'h8123, 13'h1455, 17'h0A123, 17'h01455, 2'd0},
    '{1'b1, 16'h8001, 8'h21, 16'h8123, 13'h1455, 17'h0A123, 17'h10855, 2'd0}, // R4
    '{1'b1, 16'h8000, 8'h83, 16'h8123, 13'h0455, 17'h0A123, 17'h10855, 2'd0}, // R7 invert
    '{1'b0, 16'h0000, 8'h00, 16'h8123, 13'h1055, 17'h0A123, 17'h05855, 2'd0}, // R7
    '{1'b0, 16'h0000, 8'h00, 16'h8123, 13'h1855, 17'h0A123, 17'h02055, 2'd0}, // R7
    '{1'b1, 16'hA000, 8'h02, 16'h8123, 13'h0055, 17'h0A123, 17'h01055, 2'd2}, // R8
    '{1'b1, 16'hA001, 8'h03, 16'h8123, 13'h0055, 17'h0A123, 17'h01055, 2'd2}, // R1
    '{1'b1, 16'hB002, 8'h01, 16'h8123, 13'h0055, 17'h0A123, 17'h01055, 2'd1}, // R1 alias
    '{1'b1, 16'hC000, 8'h05, 16'h8123, 13'h0455, 17'h0A123, 17'h10855, 2'd1}, // R1
    '{1'b1, 16'h0001, 8'h07, 16'h8123, 13'h0455, 17'h0A123, 17'h10855, 2'd1}, // R1 bit15 low
    '{1'b1, 16'hFFFE, 8'hAA, 16'h8123, 13'h1455, 17'h0A123, 17'h05C55, 2'd1}, // R1
    '{1'b1, 16'hA000, 8'h03, 16'h8123, 13'h1455, 17'h0A123, 17'h05C55, 2'd3}  // R8
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] cpu_addr_i = '0;
  logic [7:0]  cpu_data_i = '0;
  logic        cpu_we_i = 1'b0;
  logic [12:0] ppu_addr_i = '0;
  logic [16:0] prg_addr_o, chr_addr_o, prg_ram, chr_ram;
  logic [1:0]  mirror_o, mirror_ram;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk_i = ~clk_i;

  bank_mapper #(.PRG_BANK_W(PW), .CHR_BANK_W(CW), .CHR_PRESENT(1'b1)) u_bank_mapper (
    .clk_i, .rst_ni, .cpu_addr_i, .cpu_data_i, .cpu_we_i, .ppu_addr_i,
    .prg_addr_o, .chr_addr_o, .mirror_o
  );

  bank_mapper #(.PRG_BANK_W(PW), .CHR_BANK_W(CW), .CHR_PRESENT(1'b0)) u_bank_mapper_ram (
    .clk_i, .rst_ni, .cpu_addr_i, .cpu_data_i, .cpu_we_i, .ppu_addr_i,
    .prg_addr_o(prg_ram), .chr_addr_o(chr_ram), .mirror_o(mirror_ram)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (2) @(posedge clk_i);
    #5 rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      cpu_we_i   = VECS[i].we;
      cpu_addr_i = VECS[i].wa;
      cpu_data_i = VECS[i].wd;
      @(posedge clk_i);
      #5;
      cpu_we_i   = 1'b0;
      cpu_addr_i = VECS[i].pa;
      ppu_addr_i = VECS[i].va;
      #5;
      check($sformatf("vec%0d prg", i), 32'(prg_addr_o), 32'(VECS[i].ep));
      check($sformatf("vec%0d chr", i), 32'(chr_addr_o), 32'(VECS[i].ec));
      check($sformatf("vec%0d mirror", i), 32'(mirror_o), 32'(VECS[i].em));
    end

    // R11: pattern-less build passes the video address straight through
    for (int w = 0; w < 8; w++) begin
      ppu_addr_i = 13'((w << 10) | 16'h0155);
      #1;
      check("R11 passthrough", 32'(chr_ram), 32'(ppu_addr_i));
    end
    check("R11 prg unaffected", 32'(prg_ram), 32'(prg_addr_o));

    // R10: mapping changes at the sampling edge, not before
    cpu_we_i = 1'b1; cpu_addr_i = 16'h8000; cpu_data_i = 8'h06;
    @(posedge clk_i);
    #5;
    cpu_addr_i = 16'h8001; cpu_data_i = 8'h04;
    #5;
    check("R10 before edge", 32'(prg_addr_o), 32'h0A001);
    @(posedge clk_i);
    #5;
    check("R10 after edge", 32'(prg_addr_o), 32'h08001);
    cpu_we_i = 1'b0;

    // R2: asynchronous reset restores the power-on map
    cpu_addr_i = 16'h8123; ppu_addr_i = 13'h1455;
    #2 rst_ni = 1'b0;
    #3;
    check("R2 reset prg0", 32'(prg_addr_o), 32'h00123);
    check("R2 reset chr slot", 32'(chr_addr_o), 32'h01455);
    check("R2 reset mirror", 32'(mirror_o), 32'd0);
    cpu_addr_i = 16'hA123; ppu_addr_i = 13'h0C55;
    #1;
    check("R2 reset prg1", 32'(prg_addr_o), 32'h02123);
    check("R2 reset pair1", 32'(chr_addr_o), 32'h00C55);
    @(negedge clk_i) rst_ni = 1'b1;
    #5;
    finish_run();
  end

endmodule